// File: doc/BRIEF.md
# Windowed Mirrored Pixel Address Sequencer

This block produces the row and column addresses that read a rectangular window out of a Bayer-pattern pixel array, one address per accepted step. The window has a programmable origin and size. Each axis can be mirrored on its own, so that the scan runs from the far edge of the window back toward its origin. Each axis can also be sub-sampled on its own in units of Bayer pairs.

A frame starts with a one-cycle strobe that captures every setting. The outer logic then pulls addresses with a step enable. Each address comes with a valid flag. Line-end and frame-end flags mark the last address of each row and of the frame. Reading pixel values and colour processing are done elsewhere.

Top module: `pix_addr_seq`

## Requirements
- R1: After reset, `pix_valid`, `line_last` and `frame_last` are low, and they stay low until a frame is started.
- R2: `frame_go` captures every `cfg_*` input. Changes to those inputs after the strobe have no effect on the running frame.
- R3: Bit 0 of `cfg_col0` is ignored. The window's column origin is `cfg_col0` with bit 0 cleared.
- R4: With no mirroring and no sub-sampling, the first address appears in the cycle after `frame_go`, at the window origin. Columns then rise by one inside a row, and rows rise by one from the origin row.
- R5: With `cfg_hflip`=1, each row scans columns downward from origin+width-1. With `cfg_vflip`=1, rows scan downward from origin+depth-1. The two flips act independently.
- R6: Codes for `cfg_csub` and `cfg_rsub`: 0 is full rate, 1 is 1/2, 2 is 1/3 and 3 is 1/4. At rate 1/N, the sequencer keeps two adjacent positions and then skips 2*(N-1), counting from the scan's starting edge. This applies to columns and to rows separately.
- R7: The window is clipped at column COLS-1 and row ROWS-1. A zero width, a zero depth, or an origin outside the array gives a frame with no valid address.
- R8: While `step` is low, the address, valid flag and end flags hold their values.
- R9: `line_last` is high with the last kept column of each row. `frame_last` is high with the last address of the frame. A step taken on that last address drops `pix_valid` in the next cycle.
- R10: A `frame_go` during a running frame abandons that frame and starts the new one. The strobe takes priority over `step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Consume the current address and advance |
| frame_go | input | 1 | Start strobe; captures the settings |
| cfg_row0 | input | RW | Window origin row |
| cfg_col0 | input | CW | Window origin column (bit 0 ignored) |
| cfg_rows | input | RW+1 | Window depth in rows |
| cfg_cols | input | CW+1 | Window width in columns |
| cfg_hflip | input | 1 | Reverse the column scan |
| cfg_vflip | input | 1 | Reverse the row scan |
| cfg_csub | input | 2 | Column sub-sample code |
| cfg_rsub | input | 2 | Row sub-sample code |
| row_addr | output | RW | Current row address |
| col_addr | output | CW | Current column address |
| pix_valid | output | 1 | Current address is part of the frame |
| line_last | output | 1 | Current address ends its row |
| frame_last | output | 1 | Current address ends the frame |

## Verification
The first address of a frame is due one clock after the edge that samples `frame_go`. Each later address is due one clock after an edge that samples `step` high, and the drop of `pix_valid` is due one clock after the final step. The end flags are decoded from the same registers, so they are due in the same cycle as the address they mark. The bench changes inputs on falling edges and reads outputs on the following falling edge, which is exactly one register stage later. For every configuration it walks the expected address sequence, and it inserts one stalled cycle per frame to confirm that the outputs hold.

// File: rtl/pix_addr_seq.sv
module pix_addr_seq #(
  parameter int COLS = 688,
  parameter int ROWS = 508,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          frame_go,
  input  logic [RW-1:0] cfg_row0,
  input  logic [CW-1:0] cfg_col0,
  input  logic [RW:0]   cfg_rows,
  input  logic [CW:0]   cfg_cols,
  input  logic          cfg_hflip,
  input  logic          cfg_vflip,
  input  logic [1:0]    cfg_csub,
  input  logic [1:0]    cfg_rsub,
  output logic [RW-1:0] row_addr,
  output logic [CW-1:0] col_addr,
  output logic          pix_valid,
  output logic          line_last,
  output logic          frame_last
);
  localparam logic [CW+1:0] COLS_W = (CW+2)'(COLS);
  localparam logic [RW+1:0] ROWS_W = (RW+2)'(ROWS);

  logic [CW-1:0] c_base;
  logic [RW-1:0] r_base;
  logic [CW:0]   c_len, c_off;
  logic [RW:0]   r_len, r_off;
  logic          h_mir, v_mir, active;
  logic [1:0]    c_sub, r_sub;

  wire [CW-1:0] col0_even = {cfg_col0[CW-1:1], 1'b0};
  wire [CW+1:0] c_room = COLS_W - (CW+2)'(col0_even);
  wire [RW+1:0] r_room = ROWS_W - (RW+2)'(cfg_row0);
  wire [CW:0] c_fit = ((CW+2)'(col0_even) >= COLS_W) ? '0 :
                      (((CW+2)'(cfg_cols) < c_room) ? cfg_cols : c_room[CW:0]);
  wire [RW:0] r_fit = ((RW+2)'(cfg_row0) >= ROWS_W) ? '0 :
                      (((RW+2)'(cfg_rows) < r_room) ? cfg_rows : r_room[RW:0]);

  wire [2:0]    c_adv = c_off[0] ? {c_sub, 1'b1} : 3'd1;
  wire [2:0]    r_adv = r_off[0] ? {r_sub, 1'b1} : 3'd1;
  wire [CW+1:0] c_nxt = (CW+2)'(c_off) + (CW+2)'(c_adv);
  wire [RW+1:0] r_nxt = (RW+2)'(r_off) + (RW+2)'(r_adv);
  wire          c_end = c_nxt >= (CW+2)'(c_len);
  wire          r_end = r_nxt >= (RW+2)'(r_len);

  wire [CW:0] c_fwd = (CW+1)'(c_base) + c_off;
  wire [CW:0] c_rev = (CW+1)'(c_base) + c_len - (CW+1)'(1) - c_off;
  wire [RW:0] r_fwd = (RW+1)'(r_base) + r_off;
  wire [RW:0] r_rev = (RW+1)'(r_base) + r_len - (RW+1)'(1) - r_off;

  assign col_addr   = h_mir ? c_rev[CW-1:0] : c_fwd[CW-1:0];
  assign row_addr   = v_mir ? r_rev[RW-1:0] : r_fwd[RW-1:0];
  assign pix_valid  = active;
  assign line_last  = active & c_end;
  assign frame_last = active & c_end & r_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      c_base <= '0;
      r_base <= '0;
      c_len  <= '0;
      r_len  <= '0;
      c_off  <= '0;
      r_off  <= '0;
      h_mir  <= 1'b0;
      v_mir  <= 1'b0;
      c_sub  <= '0;
      r_sub  <= '0;
    end else if (frame_go) begin
      active <= (c_fit != '0) && (r_fit != '0);
      c_base <= col0_even;
      r_base <= cfg_row0;
      c_len  <= c_fit;
      r_len  <= r_fit;
      c_off  <= '0;
      r_off  <= '0;
      h_mir  <= cfg_hflip;
      v_mir  <= cfg_vflip;
      c_sub  <= cfg_csub;
      r_sub  <= cfg_rsub;
    end else if (active && step) begin
      if (!c_end) begin
        c_off <= c_nxt[CW:0];
      end else begin
        c_off <= '0;
        if (r_end) active <= 1'b0;
        else       r_off  <= r_nxt[RW:0];
      end
    end
  end
endmodule

module pix_addr_seq_chk #(
  parameter int COLS = 688,
  parameter int ROWS = 508,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          frame_go,
  input logic [RW-1:0] cfg_row0,
  input logic [CW-1:0] cfg_col0,
  input logic [RW:0]   cfg_rows,
  input logic [CW:0]   cfg_cols,
  input logic          cfg_hflip,
  input logic          cfg_vflip,
  input logic [1:0]    cfg_csub,
  input logic [1:0]    cfg_rsub,
  input logic [RW-1:0] row_addr,
  input logic [CW-1:0] col_addr,
  input logic          pix_valid,
  input logic          line_last,
  input logic          frame_last
);
  a_r9_line_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |-> pix_valid);
  a_r9_frame_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> line_last);
  a_r7_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (int'(col_addr) < COLS) && (int'(row_addr) < ROWS));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !step && !frame_go) |=>
      (pix_valid && $stable(col_addr) && $stable(row_addr) && $stable(line_last)));
  a_r9_frame_done: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && step && !frame_go) |=> !pix_valid);
  a_r4_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && step && !line_last && !frame_go) |=> (pix_valid && $stable(row_addr)));
  a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !frame_go) |=> !pix_valid);
endmodule

bind pix_addr_seq pix_addr_seq_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (.*);

// File: tb/pix_addr_seq_bench.sv
module pix_addr_seq_bench;
  localparam int COLS = 12;
  localparam int ROWS = 10;
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, frame_go = 1'b0;
  logic [RW-1:0] cfg_row0 = '0;
  logic [CW-1:0] cfg_col0 = '0;
  logic [RW:0]   cfg_rows = '0;
  logic [CW:0]   cfg_cols = '0;
  logic cfg_hflip = 1'b0, cfg_vflip = 1'b0;
  logic [1:0] cfg_csub = '0, cfg_rsub = '0;
  logic [RW-1:0] row_addr;
  logic [CW-1:0] col_addr;
  logic pix_valid, line_last, frame_last;
  int n_chk = 0, n_bad = 0;

  always #5ns clk = ~clk;

  pix_addr_seq #(.COLS(COLS), .ROWS(ROWS)) u_pix_addr_seq (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int c0, input int cn, input int r0, input int rn,
                           input bit hm, input bit vm, input int cs, input int rs,
                           input int stop_after);
    int ce, cl, rl, n, er, ec;
    bit lc, lr;
    @(negedge clk);
    cfg_col0 = CW'(c0); cfg_cols = (CW+1)'(cn); cfg_row0 = RW'(r0); cfg_rows = (RW+1)'(rn);
    cfg_hflip = hm; cfg_vflip = vm; cfg_csub = 2'(cs); cfg_rsub = 2'(rs);
    frame_go = 1'b1; step = 1'b0;
    @(negedge clk);
    frame_go = 1'b0;
    // R2: scramble settings after the strobe
    cfg_col0 = ~cfg_col0; cfg_cols = 1; cfg_row0 = ~cfg_row0; cfg_rows = 1;
    cfg_hflip = ~hm; cfg_vflip = ~vm; cfg_csub = ~cfg_csub; cfg_rsub = ~cfg_rsub;
    step = 1'b1;
    ce = c0 & ~1;
    cl = (ce >= COLS) ? 0 : ((cn < COLS - ce) ? cn : COLS - ce);
    rl = (r0 >= ROWS) ? 0 : ((rn < ROWS - r0) ? rn : ROWS - r0);
    if (cl == 0 || rl == 0) begin
      chk(pix_valid == 1'b0, "R7 empty window valid", int'(pix_valid), 0);
      step = 1'b0;
      return;
    end
    n = 0;
    for (int ro = 0; ro < rl; ro += ((ro % 2) != 0 ? 2*rs+1 : 1)) begin
      for (int co = 0; co < cl; co += ((co % 2) != 0 ? 2*cs+1 : 1)) begin
        er = vm ? r0 + rl - 1 - ro : r0 + ro;
        ec = hm ? ce + cl - 1 - co : ce + co;
        lc = (co + ((co % 2) != 0 ? 2*cs+1 : 1)) >= cl;
        lr = (ro + ((ro % 2) != 0 ? 2*rs+1 : 1)) >= rl;
        if (n == stop_after) begin
          step = 1'b0;
          return;
        end
        chk(pix_valid == 1'b1, "R10 valid", int'(pix_valid), 1);
        chk(int'(col_addr) == ec, "R2 R3 R4 R5 R6 R7 col", int'(col_addr), ec);
        chk(int'(row_addr) == er, "R2 R4 R5 R6 R7 row", int'(row_addr), er);
        chk(line_last == lc, "R9 line_last", int'(line_last), int'(lc));
        chk(frame_last == (lc && lr), "R9 frame_last", int'(frame_last), int'(lc && lr));
        if (n == 2) begin
          step = 1'b0;
          @(negedge clk);
          chk(pix_valid && int'(col_addr) == ec && int'(row_addr) == er,
              "R8 stall hold", int'(col_addr), ec);
          step = 1'b1;
        end
        @(negedge clk);
        n++;
      end
    end
    step = 1'b0;
    chk(pix_valid == 1'b0, "R9 valid after end", int'(pix_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pix_valid && !line_last && !frame_last, "R1 reset flags",
        int'({pix_valid, line_last, frame_last}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pix_valid && !line_last && !frame_last, "R1 idle flags",
        int'({pix_valid, line_last, frame_last}), 0);
    for (int w = 0; w < 3; w++)
      for (int m = 0; m < 4; m++)
        for (int cs = 0; cs < 4; cs++)
          for (int rs = 0; rs < 4; rs++) begin
            case (w)
              0: run_frame(3, 7, 1, 6, m[0], m[1], cs, rs, -1);
              1: run_frame(9, 9, 7, 5, m[0], m[1], cs, rs, -1);
              default: run_frame(0, 12, 0, 10, m[0], m[1], cs, rs, -1);
            endcase
          end
    run_frame(4, 0, 2, 3, 1'b0, 1'b0, 0, 0, -1);
    run_frame(4, 3, 2, 0, 1'b0, 1'b0, 0, 0, -1);
    run_frame(13, 4, 2, 3, 1'b0, 1'b0, 0, 0, -1);
    run_frame(2, 4, 10, 3, 1'b0, 1'b0, 0, 0, -1);
    // R10: restart while a frame is running
    run_frame(0, 12, 0, 10, 1'b0, 1'b0, 0, 0, 5);
    run_frame(5, 5, 3, 4, 1'b1, 1'b0, 1, 0, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule